// File: doc/BRIEF.md
# Odd-Even Merge Sorting Network

This block sorts a vector of `N` unsigned keys, each `W` bits wide, into ascending order. The keys arrive together on one flat bus, qualified by a valid bit. The sorted keys leave together on a second flat bus, also qualified by a valid bit. Lane `i` occupies bits `[i*W +: W]` on both buses. On the output, lane 0 holds the smallest key.

The network is built by recursive merging. Adjacent lanes are first sorted into pairs. Pairs are then merged into runs of four, and so on, until two sorted halves of `N/2` keys merge into the final result. Each merge of two sorted runs of length `m` splits into two half-size merges. One half-size merge handles the odd-indexed keys of both runs and the other handles the even-indexed keys. A final column of `m-1` compare-exchange elements then joins their results.

A pipeline register follows every comparator column, so the block accepts a new vector on every clock and returns results in the order they entered. With `L = log2(N)` the network has `L*(L+1)/2` columns. That is 6 for the default `N = 8`. Equal keys may leave in either order.

Top module: `odd_even_sorter`

## Requirements
- R1: Whenever `out_valid` is high, the lanes of `out_data` are in non-decreasing unsigned order from lane 0 (bits `[W-1:0]`) up to lane `N-1`.
- R2: Each valid output vector holds exactly the same multiset of keys as the input vector it came from, so no key is lost, duplicated or altered.
- R3: A vector presented with `in_valid` high appears with `out_valid` high exactly `L*(L+1)/2` clock edges later, where `L = log2(N)` (6 edges for `N = 8`).
- R4: A new vector may be presented on every clock, and back-to-back vectors leave back-to-back, in the same order they entered.
- R5: A synchronous active-high `rst` clears every valid bit in the pipeline. `out_valid` is low on the cycle after any clock edge that saw `rst` high, even when `in_valid` was high at the same time.
- R6: Data presented while `in_valid` is low never produces a high `out_valid`, whatever its value.
- R7: Keys compare as unsigned numbers. A key with its top bit set (for example `16'h8000`) sorts after every key with that bit clear (for example `16'h7FFF`), and all-zero and all-ones keys sort to the two ends.
- R8: Every vector built only from the minimum and maximum key values, across all `2^N` such patterns, is sorted correctly. This covers all 256 patterns for `N = 8`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Qualifies `in_data` on this cycle |
| in_data | input | N*W | Unsorted keys, lane `i` at bits `[i*W +: W]` |
| out_valid | output | 1 | Qualifies `out_data` on this cycle |
| out_data | output | N*W | Sorted keys, smallest in lane 0 |

## Verification
The bound checker watches every column boundary on every cycle. It confirms that each column's valid bit is the previous column's valid bit one edge later, which gives the overall latency and the effect of a reset. It confirms that the sum of the keys is preserved through every column, as a running test that keys are exchanged but never corrupted. It also confirms that any valid output is ascending. Only the bench's scenarios can show that the output is exactly the sorted input. Those scenarios cover the exhaustive min/max patterns, the unsigned ordering across the top bit, streaming without gaps, bubbles carrying garbage data, and a reset arriving while vectors are in flight.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  // Ceiling log2 for elaboration-time sizing.
  function automatic int log2_ceil(input int n);
    int r;
    r = 0;
    for (int v = 1; v < n; v = v * 2) r = r + 1;
    return r;
  endfunction

  // Number of comparator columns: one per (merge size, distance) step.
  function automatic int num_columns(input int n);
    int l;
    l = log2_ceil(n);
    return (l * (l + 1)) / 2;
  endfunction

  // Half-size of the runs being merged in column s.
  function automatic int column_run(input int n, input int s);
    int cnt;
    cnt = 0;
    for (int p = 1; p < n; p = p * 2) begin
      for (int k = p; k >= 1; k = k / 2) begin
        if (cnt == s) return p;
        cnt = cnt + 1;
      end
    end
    return 1;
  endfunction

  // Lane distance spanned by the comparators of column s.
  function automatic int column_span(input int n, input int s);
    int cnt;
    cnt = 0;
    for (int p = 1; p < n; p = p * 2) begin
      for (int k = p; k >= 1; k = k / 2) begin
        if (cnt == s) return k;
        cnt = cnt + 1;
      end
    end
    return 1;
  endfunction

  // True when lane x is the upper (smaller-key) end of a comparator in a
  // column with run size p and span k.
  function automatic bit is_low_end(input int n, input int p, input int k, input int x);
    int base;
    base = k % p;
    if (x < base) return 1'b0;
    if (((x - base) % (2 * k)) >= k) return 1'b0;
    if (x + k >= n) return 1'b0;
    return (x / (2 * p)) == ((x + k) / (2 * p));
  endfunction

  // Partner lane of lane x in column s; returns x when the lane passes through.
  function automatic int partner_lane(input int n, input int s, input int x);
    int p;
    int k;
    p = column_run(n, s);
    k = column_span(n, s);
    if (is_low_end(n, p, k, x)) return x + k;
    if (x - k >= 0 && is_low_end(n, p, k, x - k)) return x - k;
    return x;
  endfunction

endpackage

// File: rtl/cmp_exchange.sv
module cmp_exchange #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic a_gt_b;
  assign a_gt_b = a > b;
  assign lo = a_gt_b ? b : a;
  assign hi = a_gt_b ? a : b;
endmodule

// File: rtl/sort_column.sv
module sort_column #(
  parameter int N = 8,
  parameter int W = 16,
  parameter int S = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [N-1:0][W-1:0] in_data,
  output logic                out_valid,
  output logic [N-1:0][W-1:0] out_data
);
  logic [N-1:0][W-1:0] exchanged;

  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam int PT = sorter_pkg::partner_lane(N, S, g);
    if (PT > g) begin : g_cmp
      cmp_exchange #(.W(W)) u_cx (
        .a (in_data[g]),
        .b (in_data[PT]),
        .lo(exchanged[g]),
        .hi(exchanged[PT])
      );
    end else if (PT == g) begin : g_pass
      assign exchanged[g] = in_data[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_data <= exchanged;
  end
endmodule

// File: rtl/odd_even_sorter.sv
module odd_even_sorter #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data
);
  localparam int DEPTH = sorter_pkg::num_columns(N);

  // Column boundaries: index 0 is the input, index DEPTH is the output.
  logic [DEPTH:0]                col_valid;
  logic [DEPTH:0][N-1:0][W-1:0]  col_data;

  assign col_valid[0] = in_valid;
  assign col_data[0]  = in_data;

  for (genvar s = 0; s < DEPTH; s++) begin : g_col
    sort_column #(.N(N), .W(W), .S(s)) u_col (
      .clk      (clk),
      .rst      (rst),
      .in_valid (col_valid[s]),
      .in_data  (col_data[s]),
      .out_valid(col_valid[s+1]),
      .out_data (col_data[s+1])
    );
  end

  assign out_valid = col_valid[DEPTH];
  assign out_data  = col_data[DEPTH];
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic                                                  clk,
  input logic                                                  rst,
  input logic [sorter_pkg::num_columns(N):0]                   col_valid,
  input logic [sorter_pkg::num_columns(N):0][N-1:0][W-1:0]     col_data,
  input logic                                                  out_valid,
  input logic [N*W-1:0]                                        out_data
);
  localparam int DEPTH = sorter_pkg::num_columns(N);
  localparam int SW    = W + sorter_pkg::log2_ceil(N) + 1;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  logic [DEPTH:0][SW-1:0] key_sum;
  always_comb begin
    for (int s = 0; s <= DEPTH; s++) begin
      key_sum[s] = '0;
      for (int i = 0; i < N; i++) key_sum[s] = key_sum[s] + SW'(col_data[s][i]);
    end
  end

  logic out_ordered;
  always_comb begin
    out_ordered = 1'b1;
    for (int i = 0; i + 1 < N; i++)
      if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) out_ordered = 1'b0;
  end

  p_out_ascending_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_ordered);

  for (genvar s = 0; s < DEPTH; s++) begin : g_chk
    p_valid_shift_r3: assert property (@(posedge clk) disable iff (rst)
      armed |-> col_valid[s+1] == $past(col_valid[s]));
    p_key_sum_r2: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(col_valid[s])) |-> key_sum[s+1] == $past(key_sum[s]));
  end

  p_reset_clears_r5: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind odd_even_sorter sorter_checker #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .col_valid(col_valid),
  .col_data (col_data),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/odd_even_sorter_test.sv
module odd_even_sorter_test;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int LG  = $clog2(N);
  localparam int LAT = LG * (LG + 1) / 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic [N*W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit             vq[$];
  logic [N*W-1:0] dq[$];

  always #2.5 clk = ~clk;

  odd_even_sorter #(.N(N), .W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j + 1 < N - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_restart();
    vq.delete();
    dq.delete();
    for (int i = 0; i < LAT; i++) vq.push_back(1'b0);
  endtask

  // One cycle: compare the outputs against the model, then drive new inputs.
  task automatic step(input bit v, input logic [N*W-1:0] d);
    bit ev;
    @(negedge clk);
    ev = vq.pop_front();
    check_bit("R3/R4/R6 out_valid", out_valid, ev);
    if (ev) check_vec("R1/R2/R7/R8 out_data", out_data, dq.pop_front());
    in_valid = v;
    in_data  = d;
    vq.push_back(v);
    if (v) dq.push_back(ref_sort(d));
  endtask

  function automatic logic [N*W-1:0] rnd_vec();
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    int lat_count;
    // Reset state (R5)
    repeat (3) @(negedge clk);
    check_bit("R5 out_valid during reset", out_valid, 1'b0);
    rst = 1'b0;
    model_restart();

    // Directed patterns back to back (R4, R7)
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(N - i);
    step(1, v);
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 3);
    step(1, v);
    step(1, {N{16'h1234}});
    step(1, {N{16'hFFFF}});
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
    step(1, v);
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 4 == 0) ? 16'hFFFF : ((i % 4 == 1) ? 16'h0000 : ((i % 4 == 2) ? 16'h8001 : 16'h7FFE));
    step(1, v);

    // Exhaustive min/max patterns (R8)
    for (int m = 0; m < (1 << N); m++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = m[i] ? 16'hFFFF : 16'h0000;
      step(1, v);
    end

    // Random traffic with bubbles carrying garbage data (R6)
    for (int n = 0; n < 600; n++) step(($urandom % 3) != 0, rnd_vec());
    for (int n = 0; n < LAT + 2; n++) step(0, rnd_vec());

    // Explicit latency count for a single vector (R3)
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = rnd_vec();
    lat_count = 0;
    @(negedge clk);
    in_valid = 1'b0;
    lat_count = 1;
    while (!out_valid && lat_count < 4 * LAT) begin
      @(negedge clk);
      lat_count++;
    end
    checks++;
    if (lat_count != LAT) begin
      errors++;
      $display("FAIL R3 latency: got %0d expected %0d", lat_count, LAT);
    end
    repeat (LAT) @(negedge clk);
    model_restart();

    // Reset with vectors in flight (R5)
    for (int n = 0; n < 3; n++) step(1, rnd_vec());
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = rnd_vec();
    @(negedge clk);
    check_bit("R5 out_valid after reset edge", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R5 out_valid held in reset", out_valid, 1'b0);
    rst = 1'b0;
    in_valid = 1'b0;
    model_restart();
    for (int n = 0; n < LAT + 1; n++) step(0, rnd_vec());
    for (int n = 0; n < 20; n++) step(1, rnd_vec());
    for (int n = 0; n < LAT + 2; n++) step(0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule